// File: doc/BRIEF.md
# Partial-Target Branch Target Buffer

This block gives the fetch stage a predicted taken target for the current fetch PC. It is a direct-mapped table of 4096 entries, indexed by PC bits 13..2. Each entry stores only the low sixteen bits of a branch target, which occupy PC bits 17..2. The prediction is rebuilt by keeping the fetch PC's bits above 17, inserting the stored bits, and clearing bits 1..0. Most taken branches land close to where they start, so the upper bits rarely change.

Execute writes the table only when a branch resolves taken. Each entry also holds a valid bit and a 4-bit partial tag taken from PC bits 17..14. A lookup whose tag does not match reports a miss, and fetch then falls through to PC+4 rather than jumping to a target left by another branch. Lookup is combinational. A write made in a cycle takes effect from the next cycle.

Top module: `btb_partial_target`

## Requirements
- R1: After reset every entry is invalid, so each lookup made before the first taken update reports lk_hit=0.
- R2: The table is direct-mapped with 4096 entries indexed by PC[13:2]. A lookup whose PC has the same bits 17..2 as a written branch hits. A lookup at a neighbouring index is not affected by that write.
- R3: On a hit, lk_target[31:18] equals lk_pc[31:18], lk_target[17:2] equals bits 17..2 of the stored resolved target, and lk_target[1:0] is 00.
- R4: An entry is written only in a cycle with up_valid=1 and up_taken=1. An update with up_taken=0, or with up_valid=0, leaves the table unchanged.
- R5: The partial tag is PC[17:14]. A lookup that shares the index but differs in those bits misses. PCs that differ only above bit 17 are not told apart: such a lookup hits and takes its upper bits from its own PC.
- R6: A write is not seen by a lookup in the same cycle. It is seen by lookups from the next cycle on.
- R7: On a hit, lk_next_pc equals lk_target. On a miss, lk_next_pc is lk_pc+4 modulo 2^32 and lk_target is zero.
- R8: A later taken write to an index replaces both the tag and the target of that entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all valid bits |
| lk_pc | input | 32 | Fetch PC to look up |
| lk_hit | output | 1 | Entry valid and partial tag matches |
| lk_target | output | 32 | Rebuilt predicted target on a hit, zero on a miss |
| lk_next_pc | output | 32 | Predicted next fetch PC |
| up_valid | input | 1 | Resolved branch update present |
| up_pc | input | 32 | PC of the resolved branch |
| up_target | input | 32 | Resolved target address |
| up_taken | input | 1 | Branch resolved taken |

## Verification
A valid bit left set or stuck would show up as a hit on the first lookup after reset. A tag or index bit wired to the wrong PC bit would show up as a hit where a miss is due, or as a miss on an entry just written, on the lookup right after the write. A fault in how the target is rebuilt changes lk_target and lk_next_pc in the same cycle as the lookup. The bench checks this with upper PC bits and low target bits that differ from those of the branch. A missing write enable, or one that ignores the taken flag, shows up one cycle after the update, through a follow-up lookup of the same entry.

// File: rtl/btb_pkg.sv
package btb_pkg;
   localparam int unsigned PC_W_DEF   = 32;
   localparam int unsigned IDX_LO_DEF = 2;
   localparam int unsigned IDX_W_DEF  = 12;
   localparam int unsigned TAG_W_DEF  = 4;
   localparam int unsigned TGT_W_DEF  = 16;
endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
   parameter int unsigned PC_W   = btb_pkg::PC_W_DEF,
   parameter int unsigned IDX_LO = btb_pkg::IDX_LO_DEF,
   parameter int unsigned IDX_W  = btb_pkg::IDX_W_DEF,
   parameter int unsigned TAG_W  = btb_pkg::TAG_W_DEF,
   localparam int unsigned TAG_WS = (TAG_W > 0) ? TAG_W : 1
) (
   input  logic [PC_W-1:0]   pc,
   output logic [IDX_W-1:0]  idx,
   output logic [TAG_WS-1:0] tag
);
   localparam int unsigned TAG_LO = IDX_LO + IDX_W;

   logic unused_split;
   assign unused_split = ^pc;

   assign idx = pc[IDX_LO +: IDX_W];

   if (TAG_W > 0) begin : g_tag
      assign tag = pc[TAG_LO +: TAG_W];
   end else begin : g_notag
      assign tag = '0;
   end
endmodule

// File: rtl/btb_table.sv
module btb_table #(
   parameter int unsigned IDX_W = btb_pkg::IDX_W_DEF,
   parameter int unsigned TAG_W = btb_pkg::TAG_W_DEF,
   parameter int unsigned TGT_W = btb_pkg::TGT_W_DEF,
   localparam int unsigned TAG_WS = (TAG_W > 0) ? TAG_W : 1,
   localparam int unsigned DEPTH  = 1 << IDX_W,
   localparam int unsigned ENT_W  = TAG_WS + TGT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_vld,
   output logic [TAG_WS-1:0] rd_tag,
   output logic [TGT_W-1:0]  rd_tgt,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_WS-1:0] wr_tag,
   input  logic [TGT_W-1:0]  wr_tgt
);
   logic [DEPTH-1:0] vld;
   logic [ENT_W-1:0] mem [DEPTH];
   logic [ENT_W-1:0] rd_ent;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld <= '0;
      else if (wr_en) vld[wr_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= {wr_tag, wr_tgt};
   end

   assign rd_ent = mem[rd_idx];
   assign rd_vld = vld[rd_idx];
   assign rd_tag = rd_ent[TGT_W +: TAG_WS];
   assign rd_tgt = rd_ent[TGT_W-1:0];

   // R2: a write marks its own entry valid from the next cycle
   assert_write_sets_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> vld[$past(wr_idx)]);

   // R4: without a write enable the valid set does not move
   assert_idle_keeps_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(vld));
endmodule

// File: rtl/btb_splice.sv
module btb_splice #(
   parameter int unsigned PC_W   = btb_pkg::PC_W_DEF,
   parameter int unsigned IDX_LO = btb_pkg::IDX_LO_DEF,
   parameter int unsigned TGT_W  = btb_pkg::TGT_W_DEF,
   localparam int unsigned HI_LO = IDX_LO + TGT_W
) (
   input  logic [PC_W-1:0]  pc,
   input  logic [TGT_W-1:0] part,
   output logic [PC_W-1:0]  full
);
   logic unused_splice;
   assign unused_splice = ^pc;

   if (HI_LO < PC_W) begin : g_keep_hi
      assign full = {pc[PC_W-1:HI_LO], part, {IDX_LO{1'b0}}};
   end else begin : g_all_part
      assign full = {part, {IDX_LO{1'b0}}};
   end
endmodule

// File: rtl/btb_partial_target.sv
module btb_partial_target #(
   parameter int unsigned PC_W   = btb_pkg::PC_W_DEF,
   parameter int unsigned IDX_LO = btb_pkg::IDX_LO_DEF,
   parameter int unsigned IDX_W  = btb_pkg::IDX_W_DEF,
   parameter int unsigned TAG_W  = btb_pkg::TAG_W_DEF,
   parameter int unsigned TGT_W  = btb_pkg::TGT_W_DEF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] lk_pc,
   output logic            lk_hit,
   output logic [PC_W-1:0] lk_target,
   output logic [PC_W-1:0] lk_next_pc,
   input  logic            up_valid,
   input  logic [PC_W-1:0] up_pc,
   input  logic [PC_W-1:0] up_target,
   input  logic            up_taken
);
   localparam int unsigned TAG_WS = (TAG_W > 0) ? TAG_W : 1;
   localparam int unsigned HI_LO  = IDX_LO + TGT_W;
   localparam logic [PC_W-1:0] STEP = PC_W'(1) << IDX_LO;

   if (IDX_LO < 1) begin : g_chk_lo
      $error("IDX_LO must leave at least one zero low bit");
   end
   if (HI_LO > PC_W) begin : g_chk_tgt
      $error("partial target does not fit in the PC");
   end
   if (IDX_LO + IDX_W + TAG_W > PC_W) begin : g_chk_tag
      $error("index plus tag exceed the PC width");
   end
   if (IDX_W < 1 || IDX_W > 16) begin : g_chk_idx
      $error("IDX_W out of supported range");
   end

   logic [IDX_W-1:0]  lk_idx, up_idx;
   logic [TAG_WS-1:0] lk_tag, up_tag;
   logic              rd_vld;
   logic [TAG_WS-1:0] rd_tag;
   logic [TGT_W-1:0]  rd_tgt;
   logic [PC_W-1:0]   spliced;
   logic              tag_ok;
   logic              wr_en;
   logic              unused_top;

   assign unused_top = ^up_target;

   btb_addr_split #(.PC_W(PC_W), .IDX_LO(IDX_LO), .IDX_W(IDX_W), .TAG_W(TAG_W))
      u_split_lk (.pc(lk_pc), .idx(lk_idx), .tag(lk_tag));

   btb_addr_split #(.PC_W(PC_W), .IDX_LO(IDX_LO), .IDX_W(IDX_W), .TAG_W(TAG_W))
      u_split_up (.pc(up_pc), .idx(up_idx), .tag(up_tag));

   assign wr_en = up_valid & up_taken;

   btb_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (lk_idx),
      .rd_vld (rd_vld),
      .rd_tag (rd_tag),
      .rd_tgt (rd_tgt),
      .wr_en  (wr_en),
      .wr_idx (up_idx),
      .wr_tag (up_tag),
      .wr_tgt (up_target[IDX_LO +: TGT_W])
   );

   if (TAG_W > 0) begin : g_tag_cmp
      assign tag_ok = (rd_tag == lk_tag);
   end else begin : g_tag_none
      assign tag_ok = 1'b1;
   end

   btb_splice #(.PC_W(PC_W), .IDX_LO(IDX_LO), .TGT_W(TGT_W))
      u_splice (.pc(lk_pc), .part(rd_tgt), .full(spliced));

   assign lk_hit     = rd_vld & tag_ok;
   assign lk_target  = lk_hit ? spliced : '0;
   assign lk_next_pc = lk_hit ? lk_target : (lk_pc + STEP);

   // R1: first cycle out of reset never hits
   assert_cold_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !lk_hit);

   // R3: low target bits are always clear on a hit
   assert_low_bits_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_target[IDX_LO-1:0] == '0));

   if (HI_LO < PC_W) begin : g_hi_chk
      // R3: upper target bits come from the fetch PC
      assert_upper_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
         lk_hit |-> (lk_target[PC_W-1:HI_LO] == lk_pc[PC_W-1:HI_LO]));
   end

   // R6: a taken write is seen by a lookup of the same PC on the next cycle
   assert_write_then_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(up_valid && up_taken) && (lk_pc == $past(up_pc))) |-> lk_hit);
endmodule

// File: tb/btb_partial_target_tb_top.sv
module btb_partial_target_tb_top;
   typedef struct {
      logic [31:0] pc;
      logic        hit;
      logic [31:0] tgt;
      logic [31:0] nxt;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        lk_hit;
   logic [31:0] lk_target;
   logic [31:0] lk_next_pc;
   logic        up_valid = 1'b0;
   logic [31:0] up_pc = '0;
   logic [31:0] up_target = '0;
   logic        up_taken = 1'b0;

   int   total = 0;
   int   bad = 0;
   bit   done = 1'b0;
   exp_t sb [$];

   always #2 clk = ~clk;

   btb_partial_target dut_i (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit),
      .lk_target(lk_target), .lk_next_pc(lk_next_pc), .up_valid(up_valid),
      .up_pc(up_pc), .up_target(up_target), .up_taken(up_taken)
   );

   // R3: keep PC[31:18], insert target[17:2], clear [1:0]
   function automatic logic [31:0] splice(logic [31:0] pc, logic [31:0] t);
      return (pc & 32'hFFFC_0000) | (t & 32'h0003_FFFC);
   endfunction

   task automatic step(input logic [31:0] pc, input logic uv, input logic [31:0] upc,
                       input logic [31:0] utgt, input logic utk, input bit chk,
                       input logic ehit, input logic [31:0] etgt, input string tag);
      exp_t e;
      @(posedge clk);
      #1;
      lk_pc = pc; up_valid = uv; up_pc = upc; up_target = utgt; up_taken = utk;
      if (chk) begin
         e.pc = pc; e.hit = ehit; e.tag = tag;
         e.tgt = ehit ? etgt : 32'h0;
         e.nxt = ehit ? etgt : pc + 32'd4;
         sb.push_back(e);
      end
   endtask

   task automatic look(input logic [31:0] pc, input logic ehit, input logic [31:0] etgt,
                       input string tag);
      step(pc, 1'b0, 32'h0, 32'h0, 1'b0, 1'b1, ehit, etgt, tag);
   endtask

   task automatic write(input logic [31:0] upc, input logic [31:0] utgt);
      step(32'h0000_0F00, 1'b1, upc, utgt, 1'b1, 1'b0, 1'b0, 32'h0, "");
   endtask

   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         total++;
         if (lk_hit !== e.hit || lk_target !== e.tgt || lk_next_pc !== e.nxt) begin
            bad++;
            $display("FAIL %s pc=%h hit=%b exp %b target=%h exp %h next=%h exp %h",
                     e.tag, e.pc, lk_hit, e.hit, lk_target, e.tgt, lk_next_pc, e.nxt);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) step(32'h0, 1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0, "");
      @(posedge clk); #1 rst_n = 1'b1;
      // R1: cold table misses; R7 next PC and wrap
      look(32'h0000_1040, 1'b0, 32'h0, "R1 cold miss");
      look(32'hFFFF_FFFC, 1'b0, 32'h0, "R7 miss wraps");
      // R6: same-cycle write invisible, then visible
      step(32'h0000_1040, 1'b1, 32'h0000_1040, 32'h0003_5678, 1'b1, 1'b1, 1'b0, 32'h0,
           "R6 same cycle miss");
      look(32'h0000_1040, 1'b1, splice(32'h0000_1040, 32'h0003_5678), "R6 R2 hit next cycle");
      // R5: alias above bit 17 hits with own upper bits
      look(32'h7FFC_1040, 1'b1, splice(32'h7FFC_1040, 32'h0003_5678), "R5 R3 alias upper");
      // R5: tag mismatch at bit 14
      look(32'h0000_5040, 1'b0, 32'h0, "R5 tag mismatch");
      // R4: not-taken and not-valid updates do nothing
      step(32'h0000_0F00, 1'b1, 32'h0000_5040, 32'h0001_0000, 1'b0, 1'b0, 1'b0, 32'h0, "");
      look(32'h0000_1040, 1'b1, splice(32'h0000_1040, 32'h0003_5678), "R4 not taken keeps entry");
      look(32'h0000_5040, 1'b0, 32'h0, "R4 not taken no write");
      step(32'h0000_0F00, 1'b0, 32'h0000_2000, 32'h0000_0124, 1'b1, 1'b0, 1'b0, 32'h0, "");
      look(32'h0000_2000, 1'b0, 32'h0, "R4 invalid update no write");
      // R8: overwrite replaces tag and target
      write(32'h0000_5040, 32'h0002_AAA8);
      look(32'h0000_5040, 1'b1, splice(32'h0000_5040, 32'h0002_AAA8), "R8 new owner hits");
      look(32'h0000_1040, 1'b0, 32'h0, "R8 old owner misses");
      // R3: low target bits cleared
      write(32'h0000_3000, 32'h0001_2347);
      look(32'h0000_3000, 1'b1, 32'h0001_2344, "R3 low bits zero");
      // R2: neighbour index untouched
      look(32'h0000_3004, 1'b0, 32'h0, "R2 neighbour miss");
      // R2: top index
      write(32'h0000_3FFC, 32'h0003_FFFC);
      look(32'h0000_3FFC, 1'b1, 32'h0003_FFFC, "R2 top index hit");
      look(32'hABC0_3FFC, 1'b1, splice(32'hABC0_3FFC, 32'h0003_FFFC), "R3 upper from lookup");
      look(32'h0000_0000, 1'b0, 32'h0, "R2 index zero miss");
      // R1: reset again clears everything
      @(posedge clk); #1 rst_n = 1'b0;
      @(posedge clk); #1 rst_n = 1'b1;
      look(32'h0000_3000, 1'b0, 32'h0, "R1 miss after re-reset");
      look(32'h0000_5040, 1'b0, 32'h0, "R1 miss after re-reset b");
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule